// File: doc/BRIEF.md
# Low-side bus overcurrent trip controller

This block guards the three low-side switches of a three-phase bridge. Each clock it receives a digital sample of the DC-bus current magnitude taken on the low side. Two trip levels apply. The overcurrent level is set at 250 % of the rated RMS load current. The short-circuit level is set at twice the rated switch current. Each level has its own confirmation filter: the sample must sit at or above that level for an unbroken run of cycles before the level trips. A trip forces all three low-side drives off, whatever their commands are. It also drives an active-low fault flag for a fixed number of cycles.

When the fault pulse ends, the drives are not simply handed back. Each phase stays forced off until its own command has been seen OFF, and then it is released on its own. No explicit reset input is needed to recover. While a trip is latched, further trips are ignored, so a short-circuit and an overcurrent that both confirm produce a single fault pulse.

A three-state machine holds the latched condition. The states are:
- `ST_RUN`: the drives follow their commands.
- `ST_FAULT`: the fault pulse is active and all drives are off.
- `ST_HOLD`: the drives wait, phase by phase, for an OFF command.

The transitions are:
- `ST_RUN` to `ST_FAULT`: either trip confirms.
- `ST_FAULT` to `ST_HOLD`: the pulse counter reaches its last cycle.
- `ST_HOLD` to `ST_RUN`: every phase that is still forced is commanded OFF in that cycle.

The thresholds and all cycle counts are parameters.

Top module: `bus_trip_ctrl`

## Requirements
- R1: An overcurrent trip is recognised in the cycle that follows OC_FILT consecutive samples with `cur_i >= OC_LEVEL`. The fault flag falls one cycle after that, which is OC_FILT+1 cycles after the first such sample.
- R2: A short-circuit trip is recognised in the cycle that follows SC_FILT consecutive samples with `cur_i >= SC_LEVEL`. The fault flag falls SC_FILT+1 cycles after the first such sample.
- R3: A single sample below a level restarts that level's count from zero. A run shorter than the filter length, even when repeated, gives no fault.
- R4: All bits of `gate_lo_o` are 0 (off) in every cycle where `fault_n_o` is 0, whatever `cmd_lo_i` is.
- R5: `fault_n_o` is active low. After a trip it stays 0 for exactly FLT_LEN consecutive cycles and is 1 at all other times.
- R6: No new trip is accepted in `ST_FAULT` or `ST_HOLD`. When both levels confirm in the same cycle, exactly one fault pulse results.
- R7: After the pulse, phase i (bit i of the buses) stays off until `cmd_lo_i[i]` has been 0 for one cycle. From the next cycle it follows its command, independently of the other phases.
- R8: During and right after reset, `fault_n_o` is 1 and `gate_lo_o` equals `cmd_lo_i`.
- R9: Outside a latched trip, `gate_lo_o` equals `cmd_lo_i` (1 = ON) in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_i | input | CUR_W | Sampled low-side bus current magnitude |
| cmd_lo_i | input | 3 | Low-side gate commands, 1 = ON |
| gate_lo_o | output | 3 | Gated low-side drives, 1 = ON |
| fault_n_o | output | 1 | Fault flag, 0 while the fault pulse runs |

## Verification
The two functions that can coincide are the confirmation of both filters: the overcurrent count and the short-circuit count can complete in the same cycle. This is provoked by holding the current between the two levels for OC_FILT−SC_FILT samples and then lifting it above the short-circuit level for SC_FILT more samples, so that both counts finish together. The run is judged correct when exactly one falling edge of the fault flag is seen, the pulse lasts FLT_LEN cycles, and current kept above both levels through `ST_FAULT` and `ST_HOLD` starts no second pulse. Random current bursts and command changes also make a trip coincide with phase releases in `ST_HOLD`; a cycle-level model in the bench judges those cases.

// File: rtl/bus_trip_pkg.sv
package bus_trip_pkg;

    localparam int PHASES = 3;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_FAULT = 2'd1,
        ST_HOLD  = 2'd2
    } trip_state_e;

endpackage

// File: rtl/trip_filter.sv
// Persistence filter: the trip is raised once the sample has been at or
// above LEVEL for FILT consecutive cycles; any lower sample restarts it.
module trip_filter #(
    parameter int CUR_W = 12,
    parameter int LEVEL = 1000,
    parameter int FILT  = 2500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CUR_W-1:0] cur_i,
    output logic             trip_o
);
    localparam int CW = $clog2(FILT + 1);
    localparam logic [CUR_W-1:0] LVL = CUR_W'(LEVEL);
    localparam logic [CW-1:0]    TOP = CW'(FILT);

    logic          over;
    logic [CW-1:0] cnt_q;

    assign over = (cur_i >= LVL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!over) begin
            cnt_q <= '0;
        end else if (cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign trip_o = (cnt_q == TOP);

    // R1 and R2: a trip is only seen after an over-level sample
    assert_trip_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        trip_o |-> $past(over));

    // R3: one low sample removes the trip in the next cycle
    assert_drop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !over |=> !trip_o);

endmodule

// File: rtl/trip_fsm.sv
// Latch state machine: run, fault pulse, and per-phase release hold.
module trip_fsm
    import bus_trip_pkg::*;
#(
    parameter int FLT_LEN = 450000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trip_i,
    input  logic [PHASES-1:0] busy_i,
    output logic              enter_o,
    output logic              hold_o,
    output logic              fault_n_o
);
    localparam int PW = $clog2(FLT_LEN + 1);
    localparam logic [PW-1:0] LAST = PW'(FLT_LEN - 1);

    trip_state_e   state_q, state_d;
    logic [PW-1:0] pcnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (trip_i)          state_d = ST_FAULT;
            ST_FAULT: if (pcnt_q == LAST)  state_d = ST_HOLD;
            ST_HOLD:  if (busy_i == '0)    state_d = ST_RUN;
            default:                       state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FAULT) pcnt_q <= pcnt_q + 1'b1;
            else                     pcnt_q <= '0;
        end
    end

    always_comb begin
        enter_o   = (state_q == ST_RUN) && trip_i;
        hold_o    = (state_q == ST_HOLD);
        fault_n_o = (state_q != ST_FAULT);
    end

    assert_pulse_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT) |-> (pcnt_q <= LAST));

    assert_pulse_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT && pcnt_q == LAST) |=> (state_q == ST_HOLD));

    assert_no_retrigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> (state_q != ST_FAULT));

endmodule

// File: rtl/phase_release.sv
// One phase: forced off from a trip until its command is seen OFF in hold.
module phase_release (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rel_en_i,
    input  logic cmd_i,
    output logic gate_o,
    output logic masked_o
);
    logic masked_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            masked_q <= 1'b0;
        end else if (set_i) begin
            masked_q <= 1'b1;
        end else if (rel_en_i && !cmd_i) begin
            masked_q <= 1'b0;
        end
    end

    assign masked_o = masked_q;
    assign gate_o   = cmd_i & ~masked_q;

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_q && !rel_en_i && !set_i) |=> masked_q);

endmodule

// File: rtl/bus_trip_ctrl.sv
module bus_trip_ctrl
    import bus_trip_pkg::*;
#(
    parameter int CUR_W    = 12,
    parameter int OC_LEVEL = 1000,
    parameter int SC_LEVEL = 2000,
    parameter int OC_FILT  = 2500,
    parameter int SC_FILT  = 500,
    parameter int FLT_LEN  = 450000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CUR_W-1:0]  cur_i,
    input  logic [PHASES-1:0] cmd_lo_i,
    output logic [PHASES-1:0] gate_lo_o,
    output logic              fault_n_o
);
    logic              oc_trip, sc_trip;
    logic              enter, hold;
    logic [PHASES-1:0] masked;

    trip_filter #(.CUR_W(CUR_W), .LEVEL(OC_LEVEL), .FILT(OC_FILT)) u_oc (
        .clk(clk), .rst_n(rst_n), .cur_i(cur_i), .trip_o(oc_trip)
    );

    trip_filter #(.CUR_W(CUR_W), .LEVEL(SC_LEVEL), .FILT(SC_FILT)) u_sc (
        .clk(clk), .rst_n(rst_n), .cur_i(cur_i), .trip_o(sc_trip)
    );

    trip_fsm #(.FLT_LEN(FLT_LEN)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .trip_i(oc_trip | sc_trip),
        .busy_i(masked & cmd_lo_i),
        .enter_o(enter), .hold_o(hold), .fault_n_o(fault_n_o)
    );

    for (genvar i = 0; i < PHASES; i++) begin : g_phase
        phase_release u_ph (
            .clk(clk), .rst_n(rst_n),
            .set_i(enter), .rel_en_i(hold),
            .cmd_i(cmd_lo_i[i]),
            .gate_o(gate_lo_o[i]), .masked_o(masked[i])
        );
    end

    assert_fault_gates_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n_o |-> (gate_lo_o == '0));

    assert_pass_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (masked == '0) |-> (gate_lo_o == cmd_lo_i));

endmodule

// File: tb/tb_bus_trip_ctrl.sv
`timescale 1ns/1ps
module tb_bus_trip_ctrl;
    localparam int CW = 10, OCL = 300, SCL = 600, OCF = 12, SCF = 4, FL = 40;

    logic clk = 0, rst_n = 0;
    logic [CW-1:0] cur = 0;
    logic [2:0] cmd = 3'b101;
    logic [2:0] gate;
    logic fault_n;

    int checks = 0, fails = 0;
    int m_oc = 0, m_sc = 0, m_st = 0, m_p = 0;
    logic [2:0] m_mask = 0;
    int stepno = 0, falls = 0, lowcnt = 0, first_low = -1;
    logic prev_f = 1'b1;

    always #2 clk = ~clk;

    bus_trip_ctrl #(.CUR_W(CW), .OC_LEVEL(OCL), .SC_LEVEL(SCL),
                    .OC_FILT(OCF), .SC_FILT(SCF), .FLT_LEN(FL)) dut (
        .clk(clk), .rst_n(rst_n), .cur_i(cur), .cmd_lo_i(cmd),
        .gate_lo_o(gate), .fault_n_o(fault_n));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (step %0d)", tag, act, exp, stepno);
        end
    endtask

    function automatic logic [2:0] exp_gate(input logic [2:0] k);
        return (m_st == 1) ? 3'b000 : (k & ~m_mask);
    endfunction

    function automatic string gate_tag();
        return (m_st == 1) ? "R4" : ((m_st == 2) ? "R7" : "R9");
    endfunction

    task automatic clr_obs();
        falls = 0; lowcnt = 0; first_low = -1; stepno = 0;
    endtask

    task automatic step(input logic [CW-1:0] c, input logic [2:0] k);
        bit oct, sct;
        cur = c; cmd = k;
        #1;
        chk(gate_tag(), gate, exp_gate(k));
        chk("R5", fault_n, (m_st != 1));
        if (prev_f && !fault_n) begin
            falls++;
            if (first_low < 0) first_low = stepno;
        end
        if (!fault_n) lowcnt++;
        prev_f = fault_n;
        @(posedge clk);
        oct = (m_oc == OCF);
        sct = (m_sc == SCF);
        case (m_st)
            0: if (oct || sct) begin m_st = 1; m_p = 0; m_mask = 3'b111; end
            1: if (m_p == FL - 1) m_st = 2; else m_p++;
            default: begin
                m_mask = m_mask & k;
                if (m_mask == 3'b000) m_st = 0;
            end
        endcase
        m_oc = (c >= OCL) ? ((m_oc < OCF) ? m_oc + 1 : OCF) : 0;
        m_sc = (c >= SCL) ? ((m_sc < SCF) ? m_sc + 1 : SCF) : 0;
        stepno++;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8", fault_n, 1);
        chk("R8", gate, 3'b101);
        rst_n = 1;
        @(negedge clk);
        chk("R8", fault_n, 1);
        chk("R8", gate, 3'b101);

        // R3: interrupted runs never trip
        clr_obs();
        repeat (OCF - 1) step(400, 3'b111);
        step(100, 3'b111);
        repeat (OCF - 1) step(400, 3'b111);
        step(0, 3'b111);
        repeat (SCF - 1) step(700, 3'b011);
        step(0, 3'b011);
        repeat (SCF - 1) step(700, 3'b011);
        repeat (5) step(0, 3'b111);
        chk("R3", falls, 0);

        // R1 overcurrent timing, R5 pulse length, R7 per-phase release
        clr_obs();
        repeat (OCF) step(400, 3'b111);
        repeat (FL + 10) step(0, 3'b111);
        chk("R1", first_low, OCF + 1);
        chk("R5", lowcnt, FL);
        chk("R5", falls, 1);
        chk("R7", gate, 3'b000);
        step(0, 3'b110);
        step(0, 3'b111);
        chk("R7", gate, 3'b001);
        step(0, 3'b000);
        step(0, 3'b111);
        chk("R9", gate, 3'b111);

        // R2 short-circuit timing
        clr_obs();
        repeat (SCF) step(700, 3'b000);
        repeat (FL + 6) step(0, 3'b000);
        chk("R2", first_low, SCF + 1);
        chk("R5", lowcnt, FL);

        // R6: both counts complete together, current held high while latched
        clr_obs();
        repeat (OCF - SCF) step(400, 3'b000);
        repeat (SCF + 1 + FL) step(700, 3'b000);
        repeat (10) step(0, 3'b000);
        chk("R6", falls, 1);
        chk("R6", lowcnt, FL);
        chk("R6", first_low, OCF + 1);

        // random bursts against the model
        for (int b = 0; b < 400; b++) begin
            int r = $urandom % 16;
            int len = 1 + $urandom % 20;
            logic [CW-1:0] v;
            logic [2:0] k = 3'($urandom);
            if (r < 9)       v = CW'($urandom % OCL);
            else if (r < 13) v = CW'(OCL + $urandom % (SCL - OCL));
            else             v = CW'(SCL + $urandom % 100);
            for (int j = 0; j < len; j++) begin
                if ($urandom % 4 == 0) k = 3'($urandom);
                step(v, k);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule